// File: doc/BRIEF.md
# Power-Management Command Port Decoder

This block sits behind a byte-wide power-management command port. Each byte that software writes to the port is decoded on the cycle that carries it. Two reserved codes turn the ACPI mode flag on or off. Every other code asks for a System Management Interrupt (SMI), but only when an enable bit in a local configuration byte is set.

The configuration byte is held inside the block and is written through its own strobe. Its reset value depends on whether the system handles SMIs at all. When it does not, the byte comes out of reset with the enable bit already set, which marks SMM set-up as done. The last command byte written is kept in a register that can be read back.

Top module: `apm_cmd_port`

## Requirements
- R1: After reset with `SMM_PRESENT`=1, `acpi_mode_o`=0, `cmd_last_o`=0x00, `cfg_o`=0x00 and `smi_req_o`=0.
- R2: With `SMM_PRESENT`=0, `cfg_o` resets to 0x02 (bit 1, the SMI enable, already set).
- R3: A command write of 0xF1 sets `acpi_mode_o` from the clock edge that ends the write cycle.
- R4: A command write of 0xF0 clears `acpi_mode_o` from the clock edge that ends the write cycle.
- R5: A command of 0xF1 or 0xF0 never raises `smi_req_o`, whatever the value of `cfg_o`.
- R6: Any other command code drives `smi_req_o` high during its write cycle, for that single cycle, when `cfg_o` bit 1 is set.
- R7: Any other command code with `cfg_o` bit 1 clear raises no SMI. Any other command code, whatever `cfg_o` holds, leaves `acpi_mode_o` unchanged.
- R8: `cmd_last_o` holds the most recent command byte, 0xF0 and 0xF1 included, from the edge after the write. Without a write it does not change.
- R9: A configuration write updates `cfg_o` at the next edge. A command in the same cycle is gated by the value `cfg_o` held before that write.
- R10: `smi_req_o` is low in every cycle in which `cmd_we_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_data_i | input | 8 | Command byte |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_data_i | input | 8 | Configuration byte write data |
| cfg_o | output | 8 | Current configuration byte; bit 1 enables SMI |
| acpi_mode_o | output | 1 | ACPI mode (SCI enable) flag |
| smi_req_o | output | 1 | SMI request pulse |
| cmd_last_o | output | 8 | Last command byte written |

## Verification
The SMI request is combinational and is due in the same cycle as the write strobe. The bench therefore samples it 1 ns after driving the inputs on the falling edge, before the rising edge that ends the write cycle. The mode flag, the last-command register and the configuration byte each pass through one register, so they are due 1 ns after that rising edge, and they are sampled there. A second instance built without SMM support gets the same stimulus, which shows the effect of its different reset value on the very first command.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SMI_EN_BIT = 1;
  localparam logic [BYTE_W-1:0] CMD_ACPI_ON  = 8'hF1;
  localparam logic [BYTE_W-1:0] CMD_ACPI_OFF = 8'hF0;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ON   = 2'd1,
    CMD_OFF  = 2'd2,
    CMD_SMI  = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/apm_cfg_reg.sv
module apm_cfg_reg #(
  parameter int unsigned       W     = 8,
  parameter logic [W-1:0]      RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_V;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
  import apm_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         we_i,
  input  logic [W-1:0] cmd_i,
  output cmd_kind_e    kind_o
);
  always_comb begin
    if (!we_i)                      kind_o = CMD_NONE;
    else if (cmd_i == CMD_ACPI_ON)  kind_o = CMD_ON;
    else if (cmd_i == CMD_ACPI_OFF) kind_o = CMD_OFF;
    else                            kind_o = CMD_SMI;
  end
endmodule

// File: rtl/apm_state_reg.sv
module apm_state_reg
  import apm_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cmd_kind_e    kind_i,
  input  logic [W-1:0] cmd_i,
  output logic         mode_o,
  output logic [W-1:0] last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= 1'b0;
      last_o <= '0;
    end else begin
      if (kind_i != CMD_NONE) last_o <= cmd_i;
      if (kind_i == CMD_ON)       mode_o <= 1'b1;
      else if (kind_i == CMD_OFF) mode_o <= 1'b0;
    end
  end
endmodule

// File: rtl/apm_cmd_port.sv
module apm_cmd_port
  import apm_pkg::*;
#(
  parameter bit SMM_PRESENT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  input  logic              cfg_we_i,
  input  logic [BYTE_W-1:0] cfg_data_i,
  output logic [BYTE_W-1:0] cfg_o,
  output logic              acpi_mode_o,
  output logic              smi_req_o,
  output logic [BYTE_W-1:0] cmd_last_o
);
  // without SMM the enable bit starts set: set-up counts as done
  localparam logic [BYTE_W-1:0] CFG_RST =
    SMM_PRESENT ? '0 : (BYTE_W'(1) << SMI_EN_BIT);

  cmd_kind_e kind;

  apm_cfg_reg #(.W(BYTE_W), .RST_V(CFG_RST)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .d_i   (cfg_data_i),
    .q_o   (cfg_o)
  );

  apm_cmd_decode #(.W(BYTE_W)) u_dec (
    .we_i  (cmd_we_i),
    .cmd_i (cmd_data_i),
    .kind_o(kind)
  );

  apm_state_reg #(.W(BYTE_W)) u_st (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kind_i(kind),
    .cmd_i (cmd_data_i),
    .mode_o(acpi_mode_o),
    .last_o(cmd_last_o)
  );

  assign smi_req_o = (kind == CMD_SMI) && cfg_o[SMI_EN_BIT];
endmodule

// File: rtl/apm_cmd_port_chk.sv
module apm_cmd_port_chk
  import apm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_we_i,
  input logic [BYTE_W-1:0] cmd_data_i,
  input logic [BYTE_W-1:0] cfg_o,
  input logic              acpi_mode_o,
  input logic              smi_req_o,
  input logic [BYTE_W-1:0] cmd_last_o
);
  p_mode_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_data_i == CMD_ACPI_ON) |=> acpi_mode_o);

  p_mode_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_data_i == CMD_ACPI_OFF) |=> !acpi_mode_o);

  p_no_smi_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && (cmd_data_i == CMD_ACPI_ON || cmd_data_i == CMD_ACPI_OFF)) |-> !smi_req_o);

  p_smi_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> cfg_o[SMI_EN_BIT]);

  p_mode_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_data_i != CMD_ACPI_ON && cmd_data_i != CMD_ACPI_OFF)
      |=> $stable(acpi_mode_o));

  p_last_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i |=> (cmd_last_o == $past(cmd_data_i)));

  p_last_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we_i |=> $stable(cmd_last_o) && $stable(acpi_mode_o));

  p_smi_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> cmd_we_i);
endmodule

bind apm_cmd_port apm_cmd_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_we_i   (cmd_we_i),
  .cmd_data_i (cmd_data_i),
  .cfg_o      (cfg_o),
  .acpi_mode_o(acpi_mode_o),
  .smi_req_o  (smi_req_o),
  .cmd_last_o (cmd_last_o)
);

// File: tb/sim_apm_cmd_port.sv
`timescale 1ns/1ps
module sim_apm_cmd_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0, cfg_we = 1'b0;
  logic [7:0] cmd_d = '0, cfg_d = '0;
  logic [7:0] cfg0, cfg1, last0, last1;
  logic       mode0, mode1, smi0, smi1;
  logic       s0, s1;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  apm_cmd_port #(.SMM_PRESENT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd_d),
    .cfg_we_i(cfg_we), .cfg_data_i(cfg_d), .cfg_o(cfg0),
    .acpi_mode_o(mode0), .smi_req_o(smi0), .cmd_last_o(last0));

  apm_cmd_port #(.SMM_PRESENT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd_d),
    .cfg_we_i(cfg_we), .cfg_data_i(cfg_d), .cfg_o(cfg1),
    .acpi_mode_o(mode1), .smi_req_o(smi1), .cmd_last_o(last1));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive after falling edge, sample smi mid-cycle, release after rising edge
  task automatic cyc(input logic cw, input logic [7:0] cv, input logic mw, input logic [7:0] mv);
    @(negedge clk);
    cfg_we = cw; cfg_d = cv; cmd_we = mw; cmd_d = mv;
    #1; s0 = smi0; s1 = smi1;
    @(posedge clk); #1;
    cfg_we = 1'b0; cmd_we = 1'b0;
  endtask

  // {cfg_bit, cmd, exp_smi, exp_mode}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 8'hF1, 1'b0, 1'b1},
    {1'b1, 8'hF1, 1'b0, 1'b1},
    {1'b1, 8'h33, 1'b1, 1'b1},
    {1'b0, 8'h33, 1'b0, 1'b1},
    {1'b1, 8'hF0, 1'b0, 1'b0},
    {1'b0, 8'hF0, 1'b0, 1'b0},
    {1'b1, 8'h00, 1'b1, 1'b0},
    {1'b1, 8'hFF, 1'b1, 1'b0},
    {1'b0, 8'hF1, 1'b0, 1'b1},
    {1'b1, 8'hF2, 1'b1, 1'b1},
    {1'b1, 8'hEF, 1'b1, 1'b1},
    {1'b0, 8'hF0, 1'b0, 1'b0}
  };

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mode", {7'b0, mode0}, 8'h00);
    chk("R1 last", last0, 8'h00);
    chk("R1 cfg", cfg0, 8'h00);
    chk("R2 cfg no-smm", cfg1, 8'h02);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 smi", {7'b0, smi0}, 8'h00);

    // first command: the instance without SMM is enabled from reset
    cyc(1'b0, 8'h00, 1'b1, 8'h33);
    chk("R7 smi off at reset", {7'b0, s0}, 8'h00);
    chk("R2 smi from reset value", {7'b0, s1}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, {6'b0, VEC[i][10], 1'b0}, 1'b0, 8'h00);
      cyc(1'b0, 8'h00, 1'b1, VEC[i][9:2]);
      chk("R5/R6/R7 smi", {7'b0, s0}, {7'b0, VEC[i][1]});
      chk("R3/R4/R7 mode", {7'b0, mode0}, {7'b0, VEC[i][0]});
      chk("R8 last", last0, VEC[i][9:2]);
    end

    // pulse lasts one cycle and needs the strobe
    cyc(1'b1, 8'h02, 1'b0, 8'h00);
    cyc(1'b0, 8'h00, 1'b1, 8'h55);
    chk("R6 smi on write", {7'b0, s0}, 8'h01);
    cyc(1'b0, 8'h00, 1'b0, 8'h55);
    chk("R10 no smi without strobe", {7'b0, s0}, 8'h00);
    chk("R8 last holds", last0, 8'h55);
    chk("R7 mode held", {7'b0, mode0}, 8'h00);

    // same-cycle config and command: old config gates
    cyc(1'b1, 8'h00, 1'b1, 8'h44);
    chk("R9 old cfg enables", {7'b0, s0}, 8'h01);
    chk("R9 cfg updated", cfg0, 8'h00);
    cyc(1'b1, 8'h02, 1'b1, 8'h45);
    chk("R9 old cfg blocks", {7'b0, s0}, 8'h00);
    chk("R9 cfg updated 2", cfg0, 8'h02);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule